// File: doc/BRIEF.md
# Readout Busy Generator and Aggregator

This block turns per-driver back-pressure and buffer state into busy signals for the trigger processor. Each readout driver has three status inputs. The first is a link flow-control stop (`xoff`). The second is a buffer-nearly-full flag (`near_full`). The third marks that an enabled input stream is running at an abnormally high sustained rate (`malf`). Four programmable bits decide whether the driver raises its own busy line: a general enable, an enable that allows busy without flow-control stop, an enable that allows busy while a stream malfunctions, and a hard disable. A global busy is formed as the OR of all driver busy lines, after each line passes a per-driver exclusion mask.

For monitoring, the block keeps two counters for every driver and for the global busy. One counts assertions, meaning rising edges. The other counts the cycles the signal was high. A free-running total-cycle counter runs beside them, so software can compute the fraction of time busy. A snapshot command latches every busy-cycle count and the total in the same cycle, so the ratio is consistent. A clear command resets the counters of any chosen contributor. All configuration, commands and counters are reached through a simple word-wide register port.

Top module: `rod_busy_ctrl`

## Requirements
- R1: With `near_full`, `xoff` and the general enable set, `malf` low and the disable clear, the driver's busy is high.
- R2: With `xoff` low, `near_full` high and `malf` low, busy is high only when both the general enable and the no-stop enable are set.
- R3: While `malf` is high, busy is high only when the general enable, the malfunction enable and `near_full` are all set, regardless of `xoff`.
- R4: A set disable bit forces the driver's busy low under every input combination, including `xoff` high.
- R5: `gbusy` is the OR over drivers of each driver's busy condition with its exclusion bit clear. A mask bit of 1 removes that driver.
- R6: `busy` and `gbusy` are registered once: an input change at a clock edge appears at the outputs after that edge and not before.
- R7: An assertion counter increments only on a low-to-high transition of its signal, so an overlap of two drivers is one global assertion.
- R8: A busy-cycle counter adds one for every cycle its signal is high. The total counter adds one every cycle. A snapshot (command bit 0) latches all busy-cycle counts and the total in the same edge, using the values from before that edge's increment.
- R9: Every counter saturates at its all-ones value (`CNT_W` bits) and does not wrap.
- R10: Command bit 1+i clears driver i's counters and bit 1+N_DRV clears the global counters and the total. When a clear and an increment fall on the same edge, the clear wins.
- R11: The register map is fixed by address, and all registers reset to zero, which leaves every busy low. Addresses 0 to 4 hold the general enable, the no-stop enable, the malfunction enable, the disable and the mask, with bit i for driver i. Writing address 5 issues a command. Address 6 reads the total snapshot. Address 8+2k reads the live assertion count of contributor k, and address 9+2k reads its busy-cycle snapshot, where k = N_DRV is the global busy. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xoff | input | N_DRV | Link flow-control stop per driver |
| near_full | input | N_DRV | Buffer nearly full per driver |
| malf | input | N_DRV | Malfunctioning enabled stream per driver |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| busy | output | N_DRV | Registered busy per driver |
| gbusy | output | 1 | Registered global busy |

## Verification
The counter clear and the counter increment can fall on the same edge. So can the snapshot and the increment, and the snapshot and a clear. The bench provokes the clear collision by raising a driver's `near_full` in the same cycle as a clear command for that driver. It then expects an assertion count of zero and a busy-cycle count equal only to the cycles after the clear. Snapshot timing is judged against an edge count taken by the bench itself: the total must equal the number of edges between clear and snapshot minus one.

// File: rtl/rod_busy_ctrl.sv
module rod_busy_ctrl #(
  parameter int N_DRV = 4,
  parameter int CNT_W = 16,
  parameter int DW    = 32,
  localparam int NC   = N_DRV + 1,
  localparam int NREG = 8 + 2 * NC,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DRV-1:0] xoff,
  input  logic [N_DRV-1:0] near_full,
  input  logic [N_DRV-1:0] malf,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [N_DRV-1:0] busy,
  output logic             gbusy
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [N_DRV-1:0] en_q, nox_q, mfe_q, dis_q, msk_q, busy_q;
  logic             gbusy_q;
  logic [CNT_W-1:0] rise_c [NC];
  logic [CNT_W-1:0] hi_c   [NC];
  logic [CNT_W-1:0] hi_s   [NC];
  logic [CNT_W-1:0] tot_c, tot_s;

  wire [N_DRV-1:0] busy_d  = ~dis_q & en_q & near_full &
                             ((malf & mfe_q) | (~malf & (xoff | nox_q)));
  wire             gbusy_d = |(busy_d & ~msk_q);
  wire [NC-1:0]    sig_d   = {gbusy_d, busy_d};
  wire [NC-1:0]    sig_q   = {gbusy_q, busy_q};

  wire          cmd  = reg_we && (reg_addr == AW'(5));
  wire          snap = cmd && reg_wdata[0];
  wire [NC-1:0] clr  = cmd ? reg_wdata[NC:1] : '0;

  assign busy  = busy_q;
  assign gbusy = gbusy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      nox_q <= '0;
      mfe_q <= '0;
      dis_q <= '0;
      msk_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(0): en_q  <= reg_wdata[N_DRV-1:0];
        AW'(1): nox_q <= reg_wdata[N_DRV-1:0];
        AW'(2): mfe_q <= reg_wdata[N_DRV-1:0];
        AW'(3): dis_q <= reg_wdata[N_DRV-1:0];
        AW'(4): msk_q <= reg_wdata[N_DRV-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      gbusy_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      gbusy_q <= gbusy_d;
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_c[k] <= '0;
        hi_c[k]   <= '0;
        hi_s[k]   <= '0;
      end else begin
        if (clr[k]) begin
          rise_c[k] <= '0;
          hi_c[k]   <= '0;
        end else begin
          if (sig_d[k] && !sig_q[k] && rise_c[k] != CMAX) rise_c[k] <= rise_c[k] + 1'b1;
          if (sig_d[k] && hi_c[k] != CMAX) hi_c[k] <= hi_c[k] + 1'b1;
        end
        if (snap) hi_s[k] <= hi_c[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_c <= '0;
      tot_s <= '0;
    end else begin
      if (clr[N_DRV])        tot_c <= '0;
      else if (tot_c != CMAX) tot_c <= tot_c + 1'b1;
      if (snap) tot_s <= tot_c;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata = DW'(en_q);
      AW'(1): reg_rdata = DW'(nox_q);
      AW'(2): reg_rdata = DW'(mfe_q);
      AW'(3): reg_rdata = DW'(dis_q);
      AW'(4): reg_rdata = DW'(msk_q);
      AW'(6): reg_rdata = DW'(tot_s);
      default: ;
    endcase
    for (int k = 0; k < NC; k++) begin
      if (reg_addr == AW'(8 + 2 * k)) reg_rdata = DW'(rise_c[k]);
      if (reg_addr == AW'(9 + 2 * k)) reg_rdata = DW'(hi_s[k]);
    end
  end

endmodule

// File: rtl/busy_chk.sv
module busy_chk #(
  parameter int N = 4,
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] near_full,
  input logic [N-1:0] busy,
  input logic         gbusy,
  input logic [N-1:0] dis,
  input logic [N-1:0] msk,
  input logic [W-1:0] grise,
  input logic         gclr
);

  for (genvar i = 0; i < N; i++) begin : g_drv
    p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dis[i] |=> !busy[i]);
    p_needs_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] |-> $past(near_full[i]));
  end

  p_global_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gbusy == |(busy & ~$past(msk)));

  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gbusy) |-> $past(|near_full));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gclr) |-> grise >= $past(grise));

  p_edge_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(gclr) && grise != $past(grise)) |-> $rose(gbusy));

endmodule

bind rod_busy_ctrl busy_chk #(.N(N_DRV), .W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .near_full(near_full), .busy(busy), .gbusy(gbusy),
  .dis(dis_q), .msk(msk_q), .grise(rise_c[N_DRV]), .gclr(clr[N_DRV])
);

// File: tb/tb_rod_busy_ctrl.sv
module tb_rod_busy_ctrl;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int DW = 32;
  localparam int AW = $clog2(8 + 2 * (N + 1));
  localparam int GK = N;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] xoff = '0, near_full = '0, malf = '0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] busy;
  logic gbusy;
  int errors = 0, checks = 0, cyc = 0;

  rod_busy_ctrl #(.N_DRV(N), .CNT_W(CW), .DW(DW)) dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a); #1; d = reg_rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0;
    waitn(2); rst_n = 1; waitn(1);

    // R11: reset state and map
    chk("R11 busy after reset", {gbusy, busy}, 0);
    for (int a = 0; a < 5; a++) begin rd(a, d); chk("R11 config reset", d, 0); end
    rd(7, d); chk("R11 unmapped", d, 0);
    rd(8 + 2 * GK, d); chk("R11 counter reset", d, 0);

    // R1..R4: full sweep of status inputs and enables
    for (int c = 0; c < 128; c++) begin
      logic xo, nf, mf, en, nx, me, ds, exp;
      string tag;
      {ds, me, nx, en, mf, nf, xo} = 7'(c);
      wr(0, {32{en}}); wr(1, {32{nx}}); wr(2, {32{me}}); wr(3, {32{ds}}); wr(4, 0);
      xoff = {N{xo}}; near_full = {N{nf}}; malf = {N{mf}};
      waitn(1);
      exp = !ds && en && nf && (mf ? me : (xo || nx));
      tag = ds ? "R4" : mf ? "R3" : xo ? "R1" : "R2";
      chk({tag, " busy sweep"}, {gbusy, busy}, {exp, {N{exp}}});
    end
    xoff = '0; near_full = '0; malf = '0;
    wr(3, 0);

    // R5: mask versus busy pattern
    wr(0, 32'hF); wr(1, 0); wr(2, 0); xoff = '1;
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 16; m++) begin
        wr(4, m); near_full = N'(p);
        waitn(1);
        chk("R5 global", {gbusy, busy}, {|(4'(p) & ~4'(m)), 4'(p)});
      end
    near_full = '0; wr(4, 0); waitn(1);

    // R6: latency
    near_full = 4'b0100; #1;
    chk("R6 before edge", {gbusy, busy}, 0);
    waitn(1);
    chk("R6 after edge", {gbusy, busy}, {1'b1, 4'b0100});
    near_full = '0; waitn(2);

    // R7/R8: counts and snapshot
    wr(1, 32'hF); xoff = '0;
    wr(5, 32'h3E); c0 = cyc;
    near_full[0] = 1; waitn(3); near_full[0] = 0; waitn(2);
    near_full[0] = 1; waitn(2); near_full[1] = 1; waitn(2); near_full[1] = 0;
    waitn(1); near_full[0] = 0; waitn(2);
    wr(5, 1);
    rd(6, d); chk("R8 total snapshot", d, cyc - c0 - 1);
    rd(8, d); chk("R7 drv0 rises", d, 2);
    rd(9, d); chk("R8 drv0 busy cycles", d, 8);
    rd(10, d); chk("R7 drv1 rises", d, 1);
    rd(11, d); chk("R8 drv1 busy cycles", d, 2);
    rd(8 + 2 * GK, d); chk("R7 global rises overlap", d, 2);
    rd(9 + 2 * GK, d); chk("R8 global busy cycles", d, 8);

    // R9: saturation
    wr(5, 32'h3E);
    near_full[1] = 1; waitn(300); near_full[1] = 0; waitn(1);
    for (int t = 0; t < 260; t++) begin near_full[2] = 1; waitn(1); near_full[2] = 0; waitn(1); end
    wr(5, 1);
    rd(11, d); chk("R9 busy cycles saturate", d, 255);
    rd(12, d); chk("R9 rises saturate", d, 255);
    rd(6, d); chk("R9 total saturates", d, 255);
    rd(8 + 2 * GK, d); chk("R9 global rises saturate", d, 255);
    rd(9 + 2 * GK, d); chk("R9 global busy saturates", d, 255);

    // R10: per-contributor clear
    wr(5, 32'h4); wr(5, 1);
    rd(10, d); chk("R10 drv1 rises cleared", d, 0);
    rd(11, d); chk("R10 drv1 busy cleared", d, 0);
    rd(12, d); chk("R10 drv2 untouched", d, 255);

    // R10: clear and rising edge on the same edge
    near_full[0] = 1; wr(5, 32'h2);
    waitn(4); near_full[0] = 0; waitn(2);
    wr(5, 1);
    rd(8, d); chk("R10 clear beats rise", d, 0);
    rd(9, d); chk("R10 clear beats busy count", d, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule